// File: doc/BRIEF.md
# Multi-Queue Transmit Scheduler

This block sits between a set of transmit queues and a smaller set of transmit FIFO channels. Software keeps a write pointer for each queue. The block keeps a read pointer for each queue and moves it forward by one each time it serves that queue. A status word for each queue holds three things: whether the queue takes part, which channel it feeds, and whether it runs in acknowledgement-scheduler mode or plain first-in-first-out mode. A global mask turns channels on and off. Several queues may feed the same channel.

Each cycle, every channel that asserts ready gets at most one grant. The grant goes to an eligible queue mapped to that channel, and queues sharing a channel are served in round-robin order. An eligible queue is active, not flagged empty, on an enabled channel, and, in acknowledgement mode, has window space left. Each queue has an empty flag. The flag follows pointer equality whenever a pointer changes, and software can also force it. The status word and the empty flags are written through embedded per-bit write enables, so one write can change only the chosen fields. A per-queue interrupt enable turns each advance of that queue's read pointer into a one-cycle event.

Top module: `txs_sched`

## Requirements
- R1: After reset, all pointers and status words are 0, every empty flag is 1, the channel-enable and interrupt-enable masks are 0, and no grant or event is asserted.
- R2: Register addresses are 6 bits wide. Bits 5:4 select the page: 0 is global, 1 is write pointer, 2 is read pointer, 3 is status. Bits 3:0 select the queue. The global page holds the channel enables at 0 (bits 7:0), the empty flags at 1 and the interrupt enables at 2 (bits 15:0). Reads return the addressed register zero-extended, combinationally.
- R3: A status write changes status bit i (i = 0..9) only when data bit 10+i is 1. Status bit 0 is active, bits 4:1 are the channel, bit 5 is window-space-left and bit 8 is acknowledgement mode.
- R4: An empty-flag write forces flag q to data bit q only when data bit 16+q is 1. Forcing takes priority over recomputation in the same cycle.
- R5: When any pointer of a queue changes (software write or advance) and that queue is not being forced, its empty flag becomes 1 if the new read and write pointers are equal, and 0 otherwise.
- R6: A queue can be granted only if it is active, its empty flag is 0 and its channel field names an enabled channel. A channel field of 8 to 15 is never served.
- R7: A queue in acknowledgement mode (bit 8 = 1) is eligible only while its window-space-left bit is 1. In plain FIFO mode that bit is ignored.
- R8: ch_grant[c] is asserted only with ch_ready[c]. Field c of ch_grant_q (bits 4c+3:4c) gives the granted queue, or 0 when there is no grant. The granted queue's read pointer increments by 1, modulo 256, at the next clock edge.
- R9: Among eligible queues on one channel, the grant goes to the first eligible queue after the last queue granted on that channel, searching upward and wrapping. After reset, the search starts at queue 0.
- R10: A software read-pointer write in the same cycle as a grant to that queue wins, and the read pointer takes the written value.
- R11: irq_evt[q] is high for exactly the one cycle after an advance of queue q when interrupt-enable bit q is 1.
- R12: Writing a queue's write pointer does not change its read pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address (page in 5:4, queue or index in 3:0) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| ch_ready | input | 8 | Per-channel request for a frame this cycle |
| ch_grant | output | 8 | Per-channel grant |
| ch_grant_q | output | 32 | Granted queue index, 4 bits per channel |
| irq_evt | output | 16 | Per-queue read-pointer advance event |

## Verification
The hardest cases to reach are the ones where two causes act on one queue in the same cycle: a forced empty flag against pointer equality, and a software read-pointer write against a grant to the same queue. The stimulus forces a queue with equal pointers to non-empty, lets it be granted once, and then rewrites its read pointer so the recomputed flag shows again. It also writes a read pointer in the cycle a grant is taken. Round-robin order is shown by putting two queues with unequal backlogs on one channel and reading back the read pointers after each grant. Acknowledgement-mode gating, out-of-range channel fields and a read-pointer wrap from 255 are each built up through masked status writes.

// File: rtl/txs_pkg.sv
package txs_pkg;
  // status word layout (behavioural: decoded by eligibility logic)
  localparam int ST_W        = 10;
  localparam int ST_ACTIVE   = 0;
  localparam int ST_CH_LSB   = 1;
  localparam int ST_CH_W     = 4;
  localparam int ST_WSL      = 5;
  localparam int ST_ACKM     = 8;
  localparam int ST_WEN_LSB  = 10;
  // empty-flag register write-enable field
  localparam int EMPTY_WEN_LSB = 16;

  typedef enum logic [1:0] {
    PG_GLOBAL = 2'd0,
    PG_WRPTR  = 2'd1,
    PG_RDPTR  = 2'd2,
    PG_STATUS = 2'd3
  } page_e;

  localparam int GL_CHEN  = 0;
  localparam int GL_EMPTY = 1;
  localparam int GL_IEN   = 2;
endpackage

// File: rtl/txs_rst_sync.sv
module txs_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/txs_queue_state.sv
module txs_queue_state
  import txs_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_we,
  input  logic             rd_we,
  input  logic             st_we,
  input  logic [31:0]      wdata,
  input  logic             empty_we,
  input  logic             empty_val,
  input  logic             adv,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [ST_W-1:0]  status,
  output logic             empty
);
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [ST_W-1:0]  st_q, st_d;
  logic             emp_q, emp_d;
  logic             ptr_chg, rd_en, st_en, emp_en;

  always_comb begin
    wr_d = wdata[PTR_W-1:0];
    if (rd_we)    rd_d = wdata[PTR_W-1:0];
    else if (adv) rd_d = rd_q + PTR_W'(1);
    else          rd_d = rd_q;
    rd_en   = rd_we | adv;
    ptr_chg = wr_we | rd_we | adv;
    for (int b = 0; b < ST_W; b++) begin
      st_d[b] = wdata[ST_WEN_LSB + b] ? wdata[b] : st_q[b];
    end
    st_en = st_we;
    if (empty_we) emp_d = empty_val;
    else          emp_d = (rd_d == (wr_we ? wr_d : wr_q));
    emp_en = empty_we | ptr_chg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      st_q  <= '0;
      emp_q <= 1'b1;
    end else begin
      if (wr_we)  wr_q  <= wr_d;
      if (rd_en)  rd_q  <= rd_d;
      if (st_en)  st_q  <= st_d;
      if (emp_en) emp_q <= emp_d;
    end
  end

  assign wr_ptr = wr_q;
  assign rd_ptr = rd_q;
  assign status = st_q;
  assign empty  = emp_q;
endmodule

// File: rtl/txs_rr_pick.sv
module txs_rr_pick #(
  parameter int N = 16,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          take,
  output logic          hit,
  output logic [IW-1:0] idx
);
  logic [IW-1:0] last_q;
  logic [IW-1:0] cand;

  always_comb begin
    hit  = 1'b0;
    idx  = '0;
    cand = '0;
    for (int k = 1; k <= N; k++) begin
      cand = IW'((int'(last_q) + k) % N);
      if (!hit && req[cand]) begin
        hit = 1'b1;
        idx = cand;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           last_q <= IW'(N - 1);
    else if (take && hit) last_q <= idx;
  end
endmodule

// File: rtl/txs_sched.sv
module txs_sched
  import txs_pkg::*;
#(
  parameter int NUM_Q  = 16,
  parameter int NUM_CH = 8,
  parameter int PTR_W  = 8,
  localparam int QW     = $clog2(NUM_Q),
  localparam int ADDR_W = QW + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic [NUM_CH-1:0]    ch_ready,
  output logic [NUM_CH-1:0]    ch_grant,
  output logic [NUM_CH*QW-1:0] ch_grant_q,
  output logic [NUM_Q-1:0]     irq_evt
);
  logic             srst_n;
  page_e            page;
  logic [QW-1:0]    sel;

  logic [NUM_CH-1:0] chen_q;
  logic [NUM_Q-1:0]  ien_q;
  logic [NUM_Q-1:0]  irq_q, irq_d;
  logic              chen_we, ien_we;

  logic [PTR_W-1:0]  wr_ptr [NUM_Q];
  logic [PTR_W-1:0]  rd_ptr [NUM_Q];
  logic [ST_W-1:0]   status [NUM_Q];
  logic [NUM_Q-1:0]  empty_v;
  logic [NUM_Q-1:0]  q_ok;
  logic [NUM_Q-1:0]  adv;

  logic [NUM_Q-1:0]  req    [NUM_CH];
  logic [QW-1:0]     pick   [NUM_CH];
  logic [NUM_CH-1:0] hit;

  txs_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  assign page = page_e'(reg_addr[ADDR_W-1 -: 2]);
  assign sel  = reg_addr[QW-1:0];

  assign chen_we = reg_we && (page == PG_GLOBAL) && (sel == QW'(GL_CHEN));
  assign ien_we  = reg_we && (page == PG_GLOBAL) && (sel == QW'(GL_IEN));

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      chen_q <= '0;
      ien_q  <= '0;
      irq_q  <= '0;
    end else begin
      if (chen_we) chen_q <= reg_wdata[NUM_CH-1:0];
      if (ien_we)  ien_q  <= reg_wdata[NUM_Q-1:0];
      irq_q <= irq_d;
    end
  end

  assign irq_d   = adv & ien_q;
  assign irq_evt = irq_q;

  // per-queue state and eligibility
  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    logic wr_we, rd_we, st_we, emp_we;

    assign wr_we  = reg_we && (page == PG_WRPTR)  && (sel == QW'(q));
    assign rd_we  = reg_we && (page == PG_RDPTR)  && (sel == QW'(q));
    assign st_we  = reg_we && (page == PG_STATUS) && (sel == QW'(q));
    assign emp_we = reg_we && (page == PG_GLOBAL) && (sel == QW'(GL_EMPTY))
                    && reg_wdata[EMPTY_WEN_LSB + q];

    txs_queue_state #(.PTR_W(PTR_W)) u_qs (
      .clk       (clk),
      .rst_n     (srst_n),
      .wr_we     (wr_we),
      .rd_we     (rd_we),
      .st_we     (st_we),
      .wdata     (reg_wdata),
      .empty_we  (emp_we),
      .empty_val (reg_wdata[q]),
      .adv       (adv[q]),
      .wr_ptr    (wr_ptr[q]),
      .rd_ptr    (rd_ptr[q]),
      .status    (status[q]),
      .empty     (empty_v[q])
    );

    assign q_ok[q] = status[q][ST_ACTIVE] && !empty_v[q] &&
                     (!status[q][ST_ACKM] || status[q][ST_WSL]);
  end

  // per-channel request vector and round-robin pick
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_comb begin
      for (int q = 0; q < NUM_Q; q++) begin
        req[c][q] = q_ok[q] && chen_q[c] &&
                    (status[q][ST_CH_LSB +: ST_CH_W] == ST_CH_W'(c));
      end
    end

    txs_rr_pick #(.N(NUM_Q)) u_rr (
      .clk   (clk),
      .rst_n (srst_n),
      .req   (req[c]),
      .take  (ch_ready[c]),
      .hit   (hit[c]),
      .idx   (pick[c])
    );

    assign ch_grant[c]              = ch_ready[c] && hit[c];
    assign ch_grant_q[c*QW +: QW]   = ch_grant[c] ? pick[c] : '0;
  end

  always_comb begin
    adv = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      for (int q = 0; q < NUM_Q; q++) begin
        if (ch_grant[c] && (pick[c] == QW'(q))) adv[q] = 1'b1;
      end
    end
  end

  // register read-back
  always_comb begin
    reg_rdata = '0;
    unique case (page)
      PG_GLOBAL: begin
        if (sel == QW'(GL_CHEN))       reg_rdata = 32'(chen_q);
        else if (sel == QW'(GL_EMPTY)) reg_rdata = 32'(empty_v);
        else if (sel == QW'(GL_IEN))   reg_rdata = 32'(ien_q);
      end
      PG_WRPTR:  reg_rdata = 32'(wr_ptr[sel]);
      PG_RDPTR:  reg_rdata = 32'(rd_ptr[sel]);
      PG_STATUS: reg_rdata = 32'(status[sel]);
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/txs_sched_chk.sv
module txs_sched_chk #(
  parameter int NUM_Q  = 16,
  parameter int NUM_CH = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] ch_ready,
  input logic [NUM_CH-1:0] ch_grant,
  input logic [NUM_CH-1:0] chen,
  input logic [NUM_Q-1:0]  adv,
  input logic [NUM_Q-1:0]  empty,
  input logic [NUM_Q-1:0]  irq_evt
);
  // R8
  grant_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_grant & ~ch_ready) == '0);

  // R6
  grant_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_grant & ~chen) == '0);

  // R8
  one_adv_per_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(adv) == $countones(ch_grant));

  // R6
  adv_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv & empty) == '0);

  // R11
  irq_after_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_evt) |-> ((irq_evt & ~$past(adv)) == '0));
endmodule

bind txs_sched txs_sched_chk #(.NUM_Q(NUM_Q), .NUM_CH(NUM_CH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ch_ready (ch_ready),
  .ch_grant (ch_grant),
  .chen     (chen_q),
  .adv      (adv),
  .empty    (empty_v),
  .irq_evt  (irq_evt)
);

// File: tb/sim_txs_sched.sv
module sim_txs_sched;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        we;
    logic [5:0]  addr;
    logic [31:0] wdata;
    logic [7:0]  ready;
    logic [7:0]  exp_g;
    logic [31:0] exp_gq;
    logic [31:0] exp_rd;
    logic [3:0]  req;
  } vec_t;

  // R1 reset view, R2 writes, R3 status, R5 recompute, R9 round-robin, R8 advance
  localparam vec_t VEC [11] = '{
    '{1'b0, 6'h01, 32'h0,       8'h00, 8'h00, 32'h00, 32'hFFFF, 4'd1},
    '{1'b1, 6'h00, 32'hFF,      8'h00, 8'h00, 32'h00, 32'h0,    4'd2},
    '{1'b1, 6'h32, 32'hFFC03,   8'h00, 8'h00, 32'h00, 32'h0,    4'd3},
    '{1'b1, 6'h35, 32'hFFC03,   8'h00, 8'h00, 32'h00, 32'h0,    4'd3},
    '{1'b1, 6'h12, 32'h2,       8'h00, 8'h00, 32'h00, 32'h0,    4'd2},
    '{1'b1, 6'h15, 32'h1,       8'h00, 8'h00, 32'h00, 32'h0,    4'd2},
    '{1'b0, 6'h01, 32'h0,       8'h00, 8'h00, 32'h00, 32'hFFDB, 4'd5},
    '{1'b0, 6'h22, 32'h0,       8'h02, 8'h02, 32'h20, 32'h0,    4'd9},
    '{1'b0, 6'h22, 32'h0,       8'h02, 8'h02, 32'h50, 32'h1,    4'd9},
    '{1'b0, 6'h25, 32'h0,       8'h02, 8'h02, 32'h20, 32'h1,    4'd8},
    '{1'b0, 6'h01, 32'h0,       8'h02, 8'h00, 32'h00, 32'hFFFF, 4'd5}
  };

  logic        clk;
  logic        rst_n;
  logic        reg_we;
  logic [5:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [7:0]  ch_ready;
  logic [7:0]  ch_grant;
  logic [31:0] ch_grant_q;
  logic [15:0] irq_evt;

  int n_chk;
  int n_fail;
  bit done;

  txs_sched u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .ch_ready   (ch_ready),
    .ch_grant   (ch_grant),
    .ch_grant_q (ch_grant_q),
    .irq_evt    (irq_evt)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [5:0] a, input logic [31:0] d,
                      input logic [7:0] rdy);
    @(negedge clk);
    reg_we    = we;
    reg_addr  = a;
    reg_wdata = d;
    ch_ready  = rdy;
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; ch_ready = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    foreach (VEC[i]) begin
      step(VEC[i].we, VEC[i].addr, VEC[i].wdata, VEC[i].ready);
      chk($sformatf("R%0d vec%0d grant", VEC[i].req, i), 32'(ch_grant), 32'(VEC[i].exp_g));
      chk($sformatf("R%0d vec%0d gq", VEC[i].req, i), ch_grant_q, VEC[i].exp_gq);
      chk($sformatf("R%0d vec%0d rdata", VEC[i].req, i), reg_rdata, VEC[i].exp_rd);
    end

    // R3 masked write changes only the channel field of queue 2
    step(1, 6'h32, 32'h7806, 0);
    step(0, 6'h32, 0, 0);
    chk("R3 masked channel", reg_rdata, 32'h007);
    // R3 data without enable bits has no effect
    step(1, 6'h32, 32'h3FF, 0);
    step(0, 6'h32, 0, 0);
    chk("R3 no enables", reg_rdata, 32'h007);

    // R4 force q2 non-empty; bit 3 without its enable left alone
    step(1, 6'h01, 32'h40000, 0);
    step(0, 6'h01, 0, 0);
    chk("R4 forced flag", reg_rdata, 32'hFFFB);
    step(0, 6'h22, 0, 8'h08);
    chk("R4 forced queue granted", 32'(ch_grant), 32'h08);
    chk("R8 grant index ch3", ch_grant_q, 32'h2000);
    step(1, 6'h22, 32'h2, 0);
    chk("R8 read pointer advanced", reg_rdata, 32'h3);
    step(0, 6'h01, 0, 0);
    chk("R5 recompute after rd write", reg_rdata, 32'hFFFF);

    // R6 disabled channel not served
    step(1, 6'h12, 32'h5, 0);
    step(1, 6'h00, 32'hF7, 0);
    step(0, 6'h00, 0, 8'h08);
    chk("R6 disabled channel grant", 32'(ch_grant), 32'h0);
    chk("R2 channel enable readback", reg_rdata, 32'hF7);
    step(1, 6'h00, 32'hFF, 0);

    // R7 acknowledgement mode needs window space
    step(1, 6'h32, 32'h40100, 0);
    step(0, 6'h32, 0, 8'h08);
    chk("R7 ack mode no window", 32'(ch_grant), 32'h0);
    chk("R7 status readback", reg_rdata, 32'h107);
    step(1, 6'h32, 32'h8020, 0);
    step(0, 6'h22, 0, 8'h08);
    chk("R7 ack mode with window", 32'(ch_grant), 32'h08);
    chk("R7 rd before advance", reg_rdata, 32'h2);

    // R11 event pulse
    step(1, 6'h02, 32'h4, 0);
    step(0, 6'h22, 0, 8'h08);
    chk("R11 no event yet", 32'(irq_evt), 32'h0);
    step(0, 6'h22, 0, 0);
    chk("R11 event pulse", 32'(irq_evt), 32'h4);
    chk("R8 rd after advance", reg_rdata, 32'h4);
    step(0, 6'h22, 0, 0);
    chk("R11 pulse one cycle", 32'(irq_evt), 32'h0);

    // R10 software rd write wins over grant
    step(1, 6'h22, 32'h40, 8'h08);
    chk("R10 grant same cycle", 32'(ch_grant), 32'h08);
    step(0, 6'h22, 0, 0);
    chk("R10 software value kept", reg_rdata, 32'h40);

    // R12 write pointer write leaves rd alone
    step(1, 6'h12, 32'h41, 0);
    step(0, 6'h22, 0, 0);
    chk("R12 rd unchanged", reg_rdata, 32'h40);

    // R8 wrap from 255
    step(1, 6'h22, 32'hFF, 0);
    step(1, 6'h12, 32'h00, 0);
    step(0, 6'h22, 0, 8'h08);
    chk("R8 wrap grant", 32'(ch_grant), 32'h08);
    step(0, 6'h22, 0, 0);
    chk("R8 wrap value", reg_rdata, 32'h0);
    step(0, 6'h01, 0, 0);
    chk("R5 empty after wrap", reg_rdata, 32'hFFFF);

    // R6 channel field out of range
    step(1, 6'h35, 32'h7812, 0);
    step(1, 6'h15, 32'h3, 0);
    step(0, 6'h01, 0, 8'hFF);
    chk("R6 out-of-range channel", 32'(ch_grant), 32'h0);
    chk("R6 q5 non-empty", reg_rdata, 32'hFFDF);

    // R1 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    step(0, 6'h35, 0, 8'hFF);
    chk("R1 status cleared", reg_rdata, 32'h0);
    chk("R1 no grant", 32'(ch_grant), 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    step(0, 6'h01, 0, 8'hFF);
    chk("R1 empty flags set", reg_rdata, 32'hFFFF);
    chk("R1 no event", 32'(irq_evt), 32'h0);

    finish_run();
  end
endmodule